// File: doc/BRIEF.md
# Registered Command Buffer with Late Parity Check

This block sits on a memory command/address bus between a controller and a group of memory devices. On each rising clock edge it registers up to 25 data bits, provided at least one of its two active-low chip-select inputs is low. It also registers a copy of the chip-select pair and two side-band enables (on-die termination and clock enable) on every edge, whatever the chip selects are doing. The registered data appears on two identical output buses, which stand in for a one-to-two fan-out.

Alongside the data path, a checker computes parity over a subset of the data bits. Two static mode pins choose the subset. The checker compares that parity with a parity input that arrives one or two clocks after the data it covers. The latency is chosen by the latency-mode pin. The block outputs the comparison result as a partial-parity bit. It also drives an active-low error flag that, once pulled low, stays low for a fixed stretch of two cycles. An active-low asynchronous reset clears all outputs and releases the error flag.

Top module: `bufpar_top`

## Requirements
- R1: While `rst_n` is low, the data outputs, the side-band outputs and `pp_out` are 0, and `err_n` is 1.
- R2: On a rising edge where at least one bit of `cs_n` is 0, `dout_a` and `dout_b` both take the value of `din` without inversion. Bit k of `din` is data input k+1.
- R3: On a rising edge where both bits of `cs_n` are 1, `dout_a`, `dout_b`, `pp_out` and `err_n` keep their values, and so does the time left in the error stretch.
- R4: `cs_q_n`, `odt_q` and `cke_q` register `cs_n`, `odt_in` and `cke_in` on every rising edge, whatever the chip selects are.
- R5: With `sel_lat`=0 and `sel_span`=0, and also in the reserved setting `sel_lat`=1 and `sel_span`=0, the covered data inputs are 2, 3, 5, 6 and 8 to 25.
- R6: With `sel_lat`=0 and `sel_span`=1, the covered data inputs are 2, 3, 5, 6 and 8 to 14.
- R7: With `sel_lat`=1 and `sel_span`=1, the covered data inputs are 1 to 6, 8 to 10, 12 and 13. The subset is chosen by the mode pins at the edge that samples the data.
- R8: `par_in` sampled at edge e is compared with the data parity sampled at edge e-1 when `sel_lat`=0, and at edge e-2 when `sel_lat`=1. The latency is chosen by `sel_lat` at edge e. Data parity from before reset counts as 0.
- R9: On an edge where a chip select is low, `pp_out` becomes the XOR of the covered data bits (from the matched edge) with `par_in`. It is 0 when the covered bits hold an even number of ones and `par_in` is 0, or an odd number and `par_in` is 1.
- R10: When `pp_out` is set to 1, `err_n` goes to 0 at the same edge. It then stays 0 for exactly two cycles that have an active chip select. A further mismatch restarts the stretch. Reset returns `err_n` to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_lat | input | 1 | Mode pin: parity latency (0: one cycle, 1: two cycles), also part of subset choice |
| sel_span | input | 1 | Mode pin: parity subset choice |
| din | input | 25 | Data inputs; bit k is data input k+1 |
| cs_n | input | 2 | Chip-select pair, active low |
| odt_in | input | 1 | Termination enable side-band input |
| cke_in | input | 1 | Clock enable side-band input |
| par_in | input | 1 | Late-arriving parity for earlier data |
| dout_a | output | 25 | Registered data, first copy |
| dout_b | output | 25 | Registered data, second copy |
| cs_q_n | output | 2 | Registered chip-select pair |
| odt_q | output | 1 | Registered termination enable |
| cke_q | output | 1 | Registered clock enable |
| pp_out | output | 1 | Partial-parity result, 1 on mismatch |
| err_n | output | 1 | Stretched parity error flag, active low |

## Verification
The hardest situation to reach is an error stretch that is interrupted by cycles where both chip selects are high, or restarted by a second mismatch while the flag is already low. The stretch must then freeze or reload instead of running out. Random stimulus alone rarely lines these up, because a uniformly random parity input makes errors almost constant. The bench therefore derives `par_in` from its own model of the delayed data parity and flips it only occasionally, so that mismatches stand alone. Directed sequences then place a single mismatch, follow it with chip-select-idle cycles, and check the flag edge by edge. A per-bit sweep of all four mode settings, with the pipeline flushed before each probe, isolates the membership of each data input in each subset.

// File: rtl/bufpar_pkg.sv
package bufpar_pkg;

    localparam int DATA_W = 25;
    localparam int CS_W   = 2;

    typedef struct packed {
        logic [DATA_W-1:0] dout;
        logic [CS_W-1:0]   cs;
        logic              odt;
        logic              cke;
    } cap_st_t;

    // Covered-bit mask; bit k stands for data input k+1.
    function automatic logic [DATA_W-1:0] cover_mask(input logic lat, input logic span);
        logic [DATA_W-1:0] m;
        for (int n = 1; n <= DATA_W; n++) begin
            logic hit;
            if (lat && span) begin
                hit = (n <= 6) || (n >= 8 && n <= 10) || (n == 12) || (n == 13);
            end else begin
                hit = (n == 2) || (n == 3) || (n == 5) || (n == 6) || (n >= 8);
                if (!lat && span) hit = hit && (n <= 14);
            end
            m[n-1] = hit;
        end
        return m;
    endfunction

endpackage

// File: rtl/bufpar_capture.sv
module bufpar_capture
    import bufpar_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic [CS_W-1:0]   cs_n,
    input  logic              odt_in,
    input  logic              cke_in,
    output logic [DATA_W-1:0] dout,
    output logic [CS_W-1:0]   cs_q_n,
    output logic              odt_q,
    output logic              cke_q
);

    cap_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cs  = cs_n;
        st_d.odt = odt_in;
        st_d.cke = cke_in;
        if (!(&cs_n)) begin
            st_d.dout = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout   = st_q.dout;
    assign cs_q_n = st_q.cs;
    assign odt_q  = st_q.odt;
    assign cke_q  = st_q.cke;

endmodule

// File: rtl/bufpar_subset.sv
module bufpar_subset
    import bufpar_pkg::*;
(
    input  logic [DATA_W-1:0] din,
    input  logic              sel_lat,
    input  logic              sel_span,
    output logic              par_o
);

    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] hit;

    assign mask = cover_mask(sel_lat, sel_span);

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign hit[i] = din[i] & mask[i];
    end

    assign par_o = ^hit;

endmodule

// File: rtl/bufpar_check.sv
module bufpar_check
    import bufpar_pkg::*;
#(
    parameter int ERR_HOLD = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dp_now,
    input  logic            sel_lat,
    input  logic            par_in,
    input  logic [CS_W-1:0] cs_n,
    output logic            pp_out,
    output logic            err_n
);

    localparam int CNT_W = $clog2(ERR_HOLD) + 1;

    typedef struct packed {
        logic             dp1;
        logic             dp2;
        logic             pp;
        logic             err_n;
        logic [CNT_W-1:0] cnt;
    } chk_st_t;

    chk_st_t st_d, st_q;
    logic    sel;
    logic    mism;

    always_comb begin
        st_d     = st_q;
        st_d.dp1 = dp_now;
        st_d.dp2 = st_q.dp1;
        sel      = sel_lat ? st_q.dp2 : st_q.dp1;
        mism     = sel ^ par_in;
        if (!(&cs_n)) begin
            st_d.pp = mism;
            if (mism) begin
                st_d.err_n = 1'b0;
                st_d.cnt   = CNT_W'(ERR_HOLD - 1);
            end else if (!st_q.err_n) begin
                if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end else begin
                    st_d.err_n = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.dp1   <= 1'b0;
            st_q.dp2   <= 1'b0;
            st_q.pp    <= 1'b0;
            st_q.err_n <= 1'b1;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pp_out = st_q.pp;
    assign err_n  = st_q.err_n;

endmodule

// File: rtl/bufpar_top.sv
module bufpar_top
    import bufpar_pkg::*;
#(
    parameter int ERR_HOLD = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_lat,
    input  logic              sel_span,
    input  logic [DATA_W-1:0] din,
    input  logic [CS_W-1:0]   cs_n,
    input  logic              odt_in,
    input  logic              cke_in,
    input  logic              par_in,
    output logic [DATA_W-1:0] dout_a,
    output logic [DATA_W-1:0] dout_b,
    output logic [CS_W-1:0]   cs_q_n,
    output logic              odt_q,
    output logic              cke_q,
    output logic              pp_out,
    output logic              err_n
);

    logic [DATA_W-1:0] dout_w;
    logic              dp_now;

    bufpar_capture u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (din),
        .cs_n   (cs_n),
        .odt_in (odt_in),
        .cke_in (cke_in),
        .dout   (dout_w),
        .cs_q_n (cs_q_n),
        .odt_q  (odt_q),
        .cke_q  (cke_q)
    );

    bufpar_subset u_sub (
        .din      (din),
        .sel_lat  (sel_lat),
        .sel_span (sel_span),
        .par_o    (dp_now)
    );

    bufpar_check #(.ERR_HOLD(ERR_HOLD)) u_chk (
        .clk     (clk),
        .rst_n   (rst_n),
        .dp_now  (dp_now),
        .sel_lat (sel_lat),
        .par_in  (par_in),
        .cs_n    (cs_n),
        .pp_out  (pp_out),
        .err_n   (err_n)
    );

    assign dout_a = dout_w;
    assign dout_b = dout_w;

endmodule

// File: rtl/bufpar_sva.sv
module bufpar_sva
    import bufpar_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] din,
    input logic [CS_W-1:0]   cs_n,
    input logic              odt_in,
    input logic              cke_in,
    input logic [DATA_W-1:0] dout_a,
    input logic [DATA_W-1:0] dout_b,
    input logic [CS_W-1:0]   cs_q_n,
    input logic              odt_q,
    input logic              cke_q,
    input logic              pp_out,
    input logic              err_n
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (dout_a == '0 && pp_out == 1'b0 && err_n == 1'b1));

    // R2
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(&cs_n) |=> (dout_a == $past(din)));

    // R2
    fanout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_a == dout_b);

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n) |=> ($stable(dout_a) && $stable(pp_out) && $stable(err_n)));

    // R4
    side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cs_q_n == $past(cs_n) && odt_q == $past(odt_in) && cke_q == $past(cke_in)));

    // R10
    mismatch_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pp_out |-> !err_n);

    // R10
    stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_n) |=> !err_n);

endmodule

bind bufpar_top bufpar_sva u_sva (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (din),
    .cs_n   (cs_n),
    .odt_in (odt_in),
    .cke_in (cke_in),
    .dout_a (dout_a),
    .dout_b (dout_b),
    .cs_q_n (cs_q_n),
    .odt_q  (odt_q),
    .cke_q  (cke_q),
    .pp_out (pp_out),
    .err_n  (err_n)
);

// File: tb/tb_bufpar_top.sv
`timescale 1ns/1ps
module tb_bufpar_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sel_lat, sel_span;
    logic [24:0] din;
    logic [1:0]  cs_n;
    logic        odt_in, cke_in, par_in;
    logic [24:0] dout_a, dout_b;
    logic [1:0]  cs_q_n;
    logic        odt_q, cke_q, pp_out, err_n;

    int checks = 0;
    int errors = 0;

    // model state
    logic [24:0] m_dout;
    logic [1:0]  m_cs;
    logic        m_odt, m_cke, m_pp, m_err, m_dp1, m_dp2;
    int          m_left;

    always #2 clk = ~clk;

    bufpar_top dut (
        .clk(clk), .rst_n(rst_n), .sel_lat(sel_lat), .sel_span(sel_span),
        .din(din), .cs_n(cs_n), .odt_in(odt_in), .cke_in(cke_in), .par_in(par_in),
        .dout_a(dout_a), .dout_b(dout_b), .cs_q_n(cs_q_n), .odt_q(odt_q),
        .cke_q(cke_q), .pp_out(pp_out), .err_n(err_n)
    );

    function automatic bit covered(input bit lat, input bit span, input int n);
        if (lat && span)       return n inside {[1:6], [8:10], 12, 13};
        else if (!lat && span) return n inside {2, 3, 5, 6, [8:14]};
        else                   return n inside {2, 3, 5, 6, [8:25]};
    endfunction

    function automatic bit data_par(input logic [24:0] d, input bit lat, input bit span);
        bit p = 1'b0;
        for (int n = 1; n <= 25; n++) if (covered(lat, span, n)) p ^= d[n-1];
        return p;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_dout = '0; m_cs = '0; m_odt = 0; m_cke = 0;
        m_pp = 0; m_err = 1; m_dp1 = 0; m_dp2 = 0; m_left = 0;
    endtask

    task automatic model_edge();
        bit sel, mism;
        sel  = sel_lat ? m_dp2 : m_dp1;
        mism = sel ^ par_in;
        if (!(&cs_n)) begin
            m_dout = din;
            m_pp   = mism;
            if (mism) begin
                m_err = 0; m_left = 1;
            end else if (!m_err) begin
                if (m_left > 0) m_left--;
                else m_err = 1;
            end
        end
        m_dp2 = m_dp1;
        m_dp1 = data_par(din, sel_lat, sel_span);
        m_cs = cs_n; m_odt = odt_in; m_cke = cke_in;
    endtask

    task automatic compare_all(input bit was_active);
        if (was_active) chk(dout_a == m_dout, "R2 dout_a", 32'(dout_a), 32'(m_dout));
        else            chk(dout_a == m_dout, "R3 dout_a hold", 32'(dout_a), 32'(m_dout));
        chk(dout_b == m_dout, "R2 dout_b", 32'(dout_b), 32'(m_dout));
        chk(pp_out == m_pp, "R9 pp_out", 32'(pp_out), 32'(m_pp));
        chk(err_n == m_err, "R10 err_n", 32'(err_n), 32'(m_err));
        chk({cs_q_n, odt_q, cke_q} == {m_cs, m_odt, m_cke}, "R4 sideband",
            32'({cs_q_n, odt_q, cke_q}), 32'({m_cs, m_odt, m_cke}));
    endtask

    // called at a negedge; returns at the next negedge
    task automatic step(input logic [24:0] d, input logic [1:0] cs, input bit lat,
                        input bit span, input bit p, input bit o, input bit k);
        bit act;
        din = d; cs_n = cs; sel_lat = lat; sel_span = span; par_in = p;
        odt_in = o; cke_in = k;
        act = !(&cs);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all(act);
    endtask

    task automatic do_reset();
        rst_n = 0;
        @(posedge clk);
        @(negedge clk);
        model_reset();
        chk(dout_a == '0 && dout_b == '0, "R1 data cleared", 32'(dout_a), 0);
        chk(pp_out == 0 && err_n == 1, "R1 flags", 32'({pp_out, err_n}), 32'(2'b01));
        chk({cs_q_n, odt_q, cke_q} == '0, "R1 sideband", 32'({cs_q_n, odt_q, cke_q}), 0);
        rst_n = 1;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog act=%0d exp=0", checks);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; din = '1; cs_n = 2'b00; sel_lat = 0; sel_span = 0;
        par_in = 1; odt_in = 1; cke_in = 1;
        repeat (3) @(negedge clk);
        do_reset();

        // subset sweep, one data input at a time (R5, R6, R7)
        for (int mode = 0; mode < 4; mode++) begin
            bit lat  = mode[0];
            bit span = mode[1];
            for (int n = 1; n <= 25; n++) begin
                string tag;
                tag = span ? (lat ? "R7 subset" : "R6 subset") : "R5 subset";
                step('0, 2'b00, lat, span, 0, 0, 0);
                step('0, 2'b00, lat, span, 0, 0, 0);
                step(25'(1) << (n - 1), 2'b01, lat, span, 0, 1, 0);
                step('0, 2'b10, lat, span, 0, 0, 1);
                if (lat) step('0, 2'b00, lat, span, 0, 0, 0);
                chk(pp_out == covered(lat, span, n), tag, 32'(pp_out), 32'(covered(lat, span, n)));
            end
        end

        // latency: one cycle (R8)
        step('0, 2'b00, 0, 0, 0, 0, 0);
        step('0, 2'b00, 0, 0, 0, 0, 0);
        step(25'h2, 2'b00, 0, 0, 0, 0, 0);
        step('0, 2'b00, 0, 0, 1, 0, 0);
        chk(pp_out == 0 && err_n == 1, "R8 one-cycle match", 32'({pp_out, err_n}), 32'(2'b01));
        // latency: two cycles, parity supplied one cycle early (R8)
        step('0, 2'b00, 1, 1, 0, 0, 0);
        step('0, 2'b00, 1, 1, 0, 0, 0);
        step(25'h2, 2'b00, 1, 1, 0, 0, 0);
        step('0, 2'b00, 1, 1, 1, 0, 0);
        chk(pp_out == 1, "R8 early parity mismatch", 32'(pp_out), 1);
        step('0, 2'b00, 1, 1, 0, 0, 0);
        chk(pp_out == 1, "R8 two-cycle slot sees missing parity", 32'(pp_out), 1);
        // correct two-cycle alignment
        step('0, 2'b00, 1, 1, 0, 0, 0);
        step('0, 2'b00, 1, 1, 0, 0, 0);
        step(25'h2, 2'b00, 1, 1, 0, 0, 0);
        step('0, 2'b00, 1, 1, 0, 0, 0);
        step('0, 2'b00, 1, 1, 1, 0, 0);
        chk(pp_out == 0, "R8 two-cycle match", 32'(pp_out), 0);
        // even count with parity 0, odd count with parity 1 (R9)
        step('0, 2'b00, 0, 0, 0, 0, 0);
        step(25'h6, 2'b00, 0, 0, 0, 0, 0);
        step(25'h2, 2'b00, 0, 0, 0, 0, 0);
        chk(pp_out == 0, "R9 even with low parity", 32'(pp_out), 0);
        step('0, 2'b00, 0, 0, 1, 0, 0);
        chk(pp_out == 0, "R9 odd with high parity", 32'(pp_out), 0);

        // stretch: single mismatch (R10)
        repeat (3) step('0, 2'b00, 0, 0, 0, 0, 0);
        step('0, 2'b00, 0, 0, 1, 0, 0);
        chk(err_n == 0, "R10 flag falls", 32'(err_n), 0);
        step('0, 2'b00, 0, 0, 0, 0, 0);
        chk(err_n == 0, "R10 flag held second cycle", 32'(err_n), 0);
        step('0, 2'b00, 0, 0, 0, 0, 0);
        chk(err_n == 1, "R10 flag released", 32'(err_n), 1);
        // stretch frozen by idle chip selects (R3)
        step('0, 2'b00, 0, 0, 1, 0, 0);
        repeat (3) step(25'h1ffffff, 2'b11, 0, 0, 0, 1, 1);
        chk(err_n == 0 && pp_out == 1, "R3 flag frozen", 32'({pp_out, err_n}), 32'(2'b10));
        chk(dout_a == '0, "R3 data held", 32'(dout_a), 0);
        step('0, 2'b00, 0, 0, 0, 0, 0);
        chk(err_n == 0, "R10 stretch resumes", 32'(err_n), 0);
        // retrigger during stretch (R10)
        step('0, 2'b00, 0, 0, 1, 0, 0);
        step('0, 2'b00, 0, 0, 0, 0, 0);
        chk(err_n == 0, "R10 retriggered low", 32'(err_n), 0);
        step('0, 2'b00, 0, 0, 0, 0, 0);
        chk(err_n == 1, "R10 retrigger released", 32'(err_n), 1);
        // reset during stretch (R1, R10)
        step('0, 2'b00, 0, 0, 1, 0, 0);
        do_reset();
        chk(err_n == 1, "R10 reset releases flag", 32'(err_n), 1);

        // random phase
        begin
            bit lat = 0, span = 0;
            void'($urandom(32'd1234));
            for (int i = 0; i < 4000; i++) begin
                logic [1:0] cs;
                bit sel, p;
                if ($urandom % 50 == 0) begin
                    lat = $urandom; span = $urandom;
                end
                cs = ($urandom % 4 == 0) ? 2'b11 : 2'($urandom % 3);
                sel = lat ? m_dp2 : m_dp1;
                p = sel ^ ($urandom % 8 == 0);
                step(25'($urandom), cs, lat, span, p, 1'($urandom), 1'($urandom));
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule